// File: doc/BRIEF.md
# Clock-Qualified Address Decoder for an 8-bit Processor Bus

This block is the glue logic between an 8-bit microprocessor and its memories and peripherals in a 64KB address space. It takes the 16-bit address bus, the read/write line and the phase-2 clock. From these it drives active-low chip enables for four regions: a 32KB RAM at the bottom of the map, an 8KB expansion region directly above it, a bank of eight 1KB peripheral slots, and a 16KB ROM at the top. It also drives one output enable that all memories share and one write enable. Both strobes are gated by the phase-2 clock.

Each chip enable follows the address directly. Memory accesses are timed by the two clock-gated strobes and not by the chip enables. The peripheral slot selects are meant for the chip-select pins of peripheral devices. These selects are not gated by the clock either, so a peripheral relies on the qualified strobes for its access timing. The block is purely combinational and holds no state.

Top module: `clk_qual_addr_decoder`

## Requirements
- R1: `ram_ce_n_o` is 0 exactly when address bit 15 is 0, which covers $0000-$7FFF.
- R2: `exp_ce_n_o` is 0 exactly when address bits 15:13 equal binary 100, which covers $8000-$9FFF.
- R3: `rom_ce_n_o` is 0 exactly when address bits 15 and 14 are both 1, which covers $C000-$FFFF.
- R4: When address bits 15:13 equal binary 101 ($A000-$BFFF), exactly one bit of `slot_sel_n_o` is 0. That bit's index equals address bits 12:10, so slot k spans $A000+k*$400 to $A3FF+k*$400.
- R5: Outside $A000-$BFFF, all eight bits of `slot_sel_n_o` are 1.
- R6: `mem_oe_n_o` is 0 exactly when `rnw_i` is 1 (read) and `phi2_i` is 1.
- R7: `mem_we_n_o` is 0 exactly when `rnw_i` is 0 (write) and `phi2_i` is 1.
- R8: For every address, exactly one of these four is active: the RAM enable, the expansion enable, the slot group (any slot select low) and the ROM enable.
- R9: `mem_oe_n_o` and `mem_we_n_o` are never 0 together, and both are 1 while `phi2_i` is 0.
- R10: No chip enable and no slot select depends on `rnw_i` or `phi2_i`. They take the same value in all four combinations of those two inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 16 | Processor address bus |
| rnw_i | input | 1 | Read/write line: 1 = read, 0 = write |
| phi2_i | input | 1 | Phase-2 clock |
| ram_ce_n_o | output | 1 | RAM chip enable, active low |
| exp_ce_n_o | output | 1 | Expansion region chip enable, active low |
| rom_ce_n_o | output | 1 | ROM chip enable, active low |
| slot_sel_n_o | output | 8 | Peripheral slot selects, active low, one per 1KB slot |
| mem_oe_n_o | output | 1 | Shared output enable, active low, clock-qualified |
| mem_we_n_o | output | 1 | Write enable, active low, clock-qualified |

## Verification
The assertions check several behaviours whenever an input changes. Exactly one region is selected, at most one slot select is low, and slot selects are low only inside the slot window. The two strobes never overlap, both strobes are released while phase-2 is low, and each strobe matches the direction of the access. Other behaviours can only be shown by the bench's exhaustive sweep. The sweep compares every output against arithmetic expectations for all addresses, both directions and both clock phases. It checks that each region boundary falls on the right address and that the slot index matches the 1KB offset. It also checks that the selects take the same value in every strobe combination.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    parameter int ADDR_W     = 16;
    parameter int SLOT_SEL_W = 3;

    localparam int SLOT_CNT  = 1 << SLOT_SEL_W;
    localparam int REGION_W  = 3;

    typedef enum logic [1:0] {
        REG_RAM  = 2'd0,
        REG_EXP  = 2'd1,
        REG_SLOT = 2'd2,
        REG_ROM  = 2'd3
    } region_e;

    typedef struct packed {
        logic ram_ce_n;
        logic exp_ce_n;
        logic rom_ce_n;
        logic slot_grp;
    } region_sel_t;

    typedef struct packed {
        logic oe_n;
        logic we_n;
    } strobe_t;

endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
    import addr_dec_pkg::*;
(
    input  logic [REGION_W-1:0] top_bits_i,
    output region_e             region_o,
    output region_sel_t         sel_o
);

    region_e     region_d;
    region_sel_t sel_d;

    always_comb begin
        if (!top_bits_i[2]) begin
            region_d = REG_RAM;
        end else if (top_bits_i[1]) begin
            region_d = REG_ROM;
        end else if (top_bits_i[0]) begin
            region_d = REG_SLOT;
        end else begin
            region_d = REG_EXP;
        end
    end

    always_comb begin
        sel_d          = '{ram_ce_n: 1'b1, exp_ce_n: 1'b1, rom_ce_n: 1'b1, slot_grp: 1'b0};
        unique case (region_d)
            REG_RAM:  sel_d.ram_ce_n = 1'b0;
            REG_EXP:  sel_d.exp_ce_n = 1'b0;
            REG_SLOT: sel_d.slot_grp = 1'b1;
            REG_ROM:  sel_d.rom_ce_n = 1'b0;
            default:  sel_d.slot_grp = 1'b0;
        endcase
    end

    assign region_o = region_d;
    assign sel_o    = sel_d;

endmodule

// File: rtl/slot_select_decode.sv
module slot_select_decode
    import addr_dec_pkg::*;
#(
    parameter int SEL_W = SLOT_SEL_W,
    localparam int CNT  = 1 << SEL_W
) (
    input  logic             grp_en_i,
    input  logic [SEL_W-1:0] idx_i,
    output logic [CNT-1:0]   sel_n_o
);

    logic [CNT-1:0] sel_n_d;

    for (genvar g = 0; g < CNT; g++) begin : g_slot
        always_comb begin
            sel_n_d[g] = !(grp_en_i && (idx_i == SEL_W'(g)));
        end
    end

    assign sel_n_o = sel_n_d;

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import addr_dec_pkg::*;
(
    input  logic    rnw_i,
    input  logic    phi2_i,
    output strobe_t strb_o
);

    strobe_t strb_d;

    always_comb begin
        strb_d.oe_n = !(rnw_i && phi2_i);
        strb_d.we_n = !(!rnw_i && phi2_i);
    end

    assign strb_o = strb_d;

endmodule

// File: rtl/clk_qual_addr_decoder.sv
module clk_qual_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W,
    parameter int SEL_BITS  = SLOT_SEL_W,
    localparam int SLOTS    = 1 << SEL_BITS,
    localparam int IDX_HI   = ADDR_BITS - REGION_W - 1
) (
    input  logic [ADDR_BITS-1:0] addr_i,
    input  logic                 rnw_i,
    input  logic                 phi2_i,
    output logic                 ram_ce_n_o,
    output logic                 exp_ce_n_o,
    output logic                 rom_ce_n_o,
    output logic [SLOTS-1:0]     slot_sel_n_o,
    output logic                 mem_oe_n_o,
    output logic                 mem_we_n_o
);

    region_e        region_q;
    region_sel_t    sel_q;
    strobe_t        strb_q;
    logic [SLOTS-1:0] slot_q;

    addr_region_decode u_region (
        .top_bits_i (addr_i[ADDR_BITS-1 -: REGION_W]),
        .region_o   (region_q),
        .sel_o      (sel_q)
    );

    slot_select_decode #(
        .SEL_W (SEL_BITS)
    ) u_slot (
        .grp_en_i (sel_q.slot_grp),
        .idx_i    (addr_i[IDX_HI -: SEL_BITS]),
        .sel_n_o  (slot_q)
    );

    strobe_gen u_strobe (
        .rnw_i  (rnw_i),
        .phi2_i (phi2_i),
        .strb_o (strb_q)
    );

    assign ram_ce_n_o   = sel_q.ram_ce_n;
    assign exp_ce_n_o   = sel_q.exp_ce_n;
    assign rom_ce_n_o   = sel_q.rom_ce_n;
    assign slot_sel_n_o = slot_q;
    assign mem_oe_n_o   = strb_q.oe_n;
    assign mem_we_n_o   = strb_q.we_n;

endmodule

// File: rtl/addr_dec_chk.sv
module addr_dec_chk #(
    parameter int ADDR_BITS = 16,
    parameter int SLOTS     = 8
) (
    input logic [ADDR_BITS-1:0] addr_i,
    input logic                 rnw_i,
    input logic                 phi2_i,
    input logic                 ram_ce_n_o,
    input logic                 exp_ce_n_o,
    input logic                 rom_ce_n_o,
    input logic [SLOTS-1:0]     slot_sel_n_o,
    input logic                 mem_oe_n_o,
    input logic                 mem_we_n_o
);

    logic slot_any;
    logic in_slot_win;

    always_comb begin
        slot_any    = !(&slot_sel_n_o);
        in_slot_win = (addr_i[ADDR_BITS-1 -: 3] == 3'b101);

        // R8: one region active for every address
        p_one_region_r8: assert ($countones({!ram_ce_n_o, !exp_ce_n_o, slot_any, !rom_ce_n_o}) == 1)
            else $error("R8 region selects not one-hot");
        // R4: never two slots at once
        p_slot_onehot_r4: assert ($onehot0(~slot_sel_n_o))
            else $error("R4 more than one slot selected");
        // R5: slots only inside their window
        p_slot_window_r5: assert (!slot_any || in_slot_win)
            else $error("R5 slot select outside window");
        // R9: strobes never overlap
        p_no_overlap_r9: assert (mem_oe_n_o || mem_we_n_o)
            else $error("R9 strobes overlap");
        // R9: strobes idle in low phase
        p_idle_low_phase_r9: assert (phi2_i || (mem_oe_n_o && mem_we_n_o))
            else $error("R9 strobe active while phase-2 low");
        // R6: output enable only on reads
        p_oe_read_r6: assert (mem_oe_n_o || rnw_i)
            else $error("R6 output enable on write");
        // R7: write enable only on writes
        p_we_write_r7: assert (mem_we_n_o || !rnw_i)
            else $error("R7 write enable on read");
    end

endmodule

bind clk_qual_addr_decoder addr_dec_chk #(
    .ADDR_BITS (ADDR_BITS),
    .SLOTS     (SLOTS)
) u_chk (
    .addr_i       (addr_i),
    .rnw_i        (rnw_i),
    .phi2_i       (phi2_i),
    .ram_ce_n_o   (ram_ce_n_o),
    .exp_ce_n_o   (exp_ce_n_o),
    .rom_ce_n_o   (rom_ce_n_o),
    .slot_sel_n_o (slot_sel_n_o),
    .mem_oe_n_o   (mem_oe_n_o),
    .mem_we_n_o   (mem_we_n_o)
);

// File: tb/tb_clk_qual_addr_decoder.sv
`timescale 1ns/100ps
module tb_clk_qual_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rnw = 1'b1;
    logic        phi2 = 1'b0;
    logic        ram_ce_n, exp_ce_n, rom_ce_n, oe_n, we_n;
    logic [7:0]  slot_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = !clk;

    clk_qual_addr_decoder dut (
        .addr_i       (addr),
        .rnw_i        (rnw),
        .phi2_i       (phi2),
        .ram_ce_n_o   (ram_ce_n),
        .exp_ce_n_o   (exp_ce_n),
        .rom_ce_n_o   (rom_ce_n),
        .slot_sel_n_o (slot_n),
        .mem_oe_n_o   (oe_n),
        .mem_we_n_o   (we_n)
    );

    task automatic chk(input string req, input logic [15:0] a, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s addr=%h rnw=%0b phi2=%0b actual=%0h expected=%0h", req, a, rnw, phi2, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int a_int;
        int exp_slot_n;
        logic [7:0] ref_slot;
        logic ref_ram, ref_exp, ref_rom;
        #12 rst_n = 1'b1;
        // reset state: phase-2 low, strobes idle (R9)
        chk("R9", addr, {oe_n, we_n}, 2'b11);
        chk("R1", addr, ram_ce_n, 0);

        for (int a = 0; a < 65536; a++) begin
            a_int = a;
            addr  = a_int[15:0];
            ref_ram = (a >= 'h8000);
            ref_exp = !(a >= 'h8000 && a < 'hA000);
            ref_rom = !(a >= 'hC000);
            exp_slot_n = 'hFF;
            if (a >= 'hA000 && a < 'hC000)
                exp_slot_n = 'hFF & ~(1 << ((a - 'hA000) / 1024));
            for (int c = 0; c < 4; c++) begin
                rnw  = c[0];
                phi2 = c[1];
                #1;
                chk("R1", addr, ram_ce_n, ref_ram);
                chk("R2", addr, exp_ce_n, ref_exp);
                chk("R3", addr, rom_ce_n, ref_rom);
                if (a >= 'hA000 && a < 'hC000) chk("R4", addr, slot_n, exp_slot_n);
                else                           chk("R5", addr, slot_n, exp_slot_n);
                chk("R6", addr, oe_n, !(c[0] && c[1]));
                chk("R7", addr, we_n, !(!c[0] && c[1]));
                chk("R8", addr, (!ram_ce_n) + (!exp_ce_n) + (!rom_ce_n) + (slot_n != 8'hFF), 1);
                chk("R9", addr, !oe_n && !we_n, 0);
                if (c == 0) ref_slot = slot_n;
                else chk("R10", addr, slot_n, ref_slot);
            end
        end
        // boundary spot checks
        rnw = 1'b1; phi2 = 1'b1;
        addr = 16'h7FFF; #1 chk("R1", addr, ram_ce_n, 0);
        addr = 16'h8000; #1 chk("R2", addr, exp_ce_n, 0);
        addr = 16'hA3FF; #1 chk("R4", addr, slot_n, 8'hFE);
        addr = 16'hBC00; #1 chk("R4", addr, slot_n, 8'h7F);
        addr = 16'hC000; #1 chk("R3", addr, rom_ce_n, 0);
        phi2 = 1'b0; #1 chk("R9", addr, {oe_n, we_n}, 2'b11);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule